// File: doc/BRIEF.md
# Single-Wire Humidity Sensor Responder

This block sits on the device side of a single-wire, open-drain temperature and humidity link. It emulates the sensor in synthesizable logic. It watches the shared data line for a host start request, which is a long low pulse. When it accepts one, it answers with a timed preamble and then a 40-bit frame in which the length of each high phase encodes one bit. The block can only pull the line low, through `pull_o`. When `pull_o` is low the line is released, and an external pull-up raises it.

The frame carries the 32-bit `payload_i` word, most significant bit first. The conventional byte order is humidity integer, humidity fraction, temperature integer, temperature fraction, and the top bit of the last byte marks a negative temperature. An 8-bit checksum follows the payload. The payload is captured when a start request is accepted, so the driving logic may update it at any time.

All timings are given in microseconds and converted to cycles through the `CLK_MHZ` parameter. The line is read through a two-flop synchronizer.

Top module: `hygro_line_responder`

## Requirements
- R1: While reset is asserted, and directly after it, `pull_o` and `busy_o` are both 0.
- R2: A start request is accepted only if the synchronized line stays low for at least `START_MIN_US*CLK_MHZ` cycles, counted from a falling edge to the following rising edge. A low pulse one cycle shorter than that causes no response: `busy_o` and `pull_o` stay 0.
- R3: After the host releases the line, `pull_o` rises `WAIT_US*CLK_MHZ` cycles later, with up to 4 cycles of extra synchronizer and detection latency. `pull_o` then stays 1 for `ACK_LO_US*CLK_MHZ` cycles and then 0 for `ACK_HI_US*CLK_MHZ` cycles.
- R4: Each bit is sent as `pull_o`=1 for `BIT_LO_US*CLK_MHZ` cycles, followed by `pull_o`=0 for `ONE_HI_US*CLK_MHZ` cycles (bit value 1) or `ZERO_HI_US*CLK_MHZ` cycles (bit value 0).
- R5: A frame has exactly 40 bits, sent most significant bit first. Bits 39..8 are `payload_i[31:0]` and bits 7..0 are the checksum.
- R6: The checksum equals the sum of the four payload bytes, modulo 256.
- R7: After the 40th bit, `pull_o` is 1 for `TAIL_LO_US*CLK_MHZ` cycles. In the cycle it drops, `busy_o` drops as well.
- R8: The payload is sampled at acceptance. Changes on `payload_i` while `busy_o` is 1 do not alter the frame being sent.
- R9: A start request issued while `busy_o` is 1 is ignored: no second frame follows. The block's own pulls on the line never trigger a new frame.
- R10: `pull_o` is asserted only while `busy_o` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, frequency `CLK_MHZ` MHz |
| rst_ni | input | 1 | Active-low asynchronous reset |
| payload_i | input | 32 | Four data bytes to send, sampled at acceptance |
| line_i | input | 1 | Level of the open-drain data line |
| pull_o | output | 1 | 1 = drive the line low, 0 = release it |
| busy_o | output | 1 | High from acceptance until the final release |

## Verification
The bench builds the block with `CLK_MHZ=1` and `START_MIN_US=200`, so every phase lasts as many cycles as it has microseconds and a start request takes 200 cycles. This brings a dozen complete frames within a short run, including all-zero and all-ones payloads and payloads whose checksum overflows. It also places the start threshold on both sides of its exact boundary, and it sends a host pulse into the middle of a frame. Every phase width and every decoded bit is measured on `pull_o` against values the bench computes itself.

// File: rtl/hygro_pkg.sv
package hygro_pkg;
  localparam int PAYLOAD_W = 32;
  localparam int FRAME_W   = PAYLOAD_W + 8;

  typedef enum logic [2:0] {
    ST_IDLE, ST_WAIT, ST_ACK_LO, ST_ACK_HI, ST_BIT_LO, ST_BIT_HI, ST_TAIL_LO
  } tx_state_e;

  function automatic logic [7:0] byte_sum(input logic [PAYLOAD_W-1:0] p);
    logic [7:0] s;
    s = 8'd0;
    for (int i = 0; i < PAYLOAD_W/8; i++) s = s + p[i*8 +: 8];
    return s;
  endfunction
endpackage

// File: rtl/hr_line_sync.sv
module hr_line_sync (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic line_i,
  output logic line_s_o
);
  logic ff1_q, ff2_q;

  // released line idles high
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ff1_q <= 1'b1;
      ff2_q <= 1'b1;
    end else begin
      ff1_q <= line_i;
      ff2_q <= ff1_q;
    end
  end

  assign line_s_o = ff2_q;
endmodule

// File: rtl/hr_start_detect.sv
module hr_start_detect #(
  parameter int START_CYC = 1800000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic line_s_i,
  input  logic busy_i,
  output logic req_o
);
  localparam int CW = $clog2(START_CYC + 1);

  logic          prev_q, armed_q;
  logic [CW-1:0] cnt_q;
  logic          fall, rise;

  assign fall = prev_q & ~line_s_i;
  assign rise = ~prev_q & line_s_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q  <= 1'b1;
      armed_q <= 1'b0;
      cnt_q   <= '0;
    end else begin
      prev_q <= line_s_i;
      if (busy_i) begin
        // own pulls and host pulses during a frame never arm
        armed_q <= 1'b0;
        cnt_q   <= '0;
      end else if (fall) begin
        armed_q <= 1'b1;
        cnt_q   <= CW'(1);
      end else if (!line_s_i && armed_q && cnt_q != CW'(START_CYC)) begin
        cnt_q <= cnt_q + CW'(1);
      end else if (rise) begin
        armed_q <= 1'b0;
      end
    end
  end

  assign req_o = rise & armed_q & (cnt_q == CW'(START_CYC)) & ~busy_i;

  assert_cnt_sat_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CW'(START_CYC));
  assert_req_after_low_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_o |-> armed_q && $past(!line_s_i));
endmodule

// File: rtl/hr_frame_sender.sv
module hr_frame_sender
  import hygro_pkg::*;
#(
  parameter int CLK_MHZ    = 100,
  parameter int WAIT_US    = 13,
  parameter int ACK_LO_US  = 83,
  parameter int ACK_HI_US  = 87,
  parameter int BIT_LO_US  = 54,
  parameter int ONE_HI_US  = 71,
  parameter int ZERO_HI_US = 24,
  parameter int TAIL_LO_US = 54
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 go_i,
  input  logic [PAYLOAD_W-1:0] payload_i,
  output logic                 pull_o,
  output logic                 busy_o
);
  localparam int WAIT_C = WAIT_US * CLK_MHZ;
  localparam int ALO_C  = ACK_LO_US * CLK_MHZ;
  localparam int AHI_C  = ACK_HI_US * CLK_MHZ;
  localparam int BLO_C  = BIT_LO_US * CLK_MHZ;
  localparam int ONE_C  = ONE_HI_US * CLK_MHZ;
  localparam int ZERO_C = ZERO_HI_US * CLK_MHZ;
  localparam int TAIL_C = TAIL_LO_US * CLK_MHZ;
  localparam int M1 = (WAIT_C > ALO_C) ? WAIT_C : ALO_C;
  localparam int M2 = (AHI_C > BLO_C) ? AHI_C : BLO_C;
  localparam int M3 = (ONE_C > ZERO_C) ? ONE_C : ZERO_C;
  localparam int M4 = (M1 > M2) ? M1 : M2;
  localparam int M5 = (M3 > TAIL_C) ? M3 : TAIL_C;
  localparam int MAX_C = (M4 > M5) ? M4 : M5;
  localparam int TW = $clog2(MAX_C + 1);
  localparam int IW = $clog2(FRAME_W + 1);

  tx_state_e          st_q;
  logic [TW-1:0]      tmr_q;
  logic [FRAME_W-1:0] frame_q;
  logic [IW-1:0]      idx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      tmr_q   <= '0;
      frame_q <= '0;
      idx_q   <= '0;
    end else if (st_q == ST_IDLE) begin
      if (go_i) begin
        st_q    <= ST_WAIT;
        tmr_q   <= TW'(WAIT_C - 1);
        frame_q <= {payload_i, byte_sum(payload_i)};
        idx_q   <= '0;
      end
    end else if (tmr_q != '0) begin
      tmr_q <= tmr_q - TW'(1);
    end else begin
      unique case (st_q)
        ST_WAIT: begin
          st_q  <= ST_ACK_LO;
          tmr_q <= TW'(ALO_C - 1);
        end
        ST_ACK_LO: begin
          st_q  <= ST_ACK_HI;
          tmr_q <= TW'(AHI_C - 1);
        end
        ST_ACK_HI: begin
          st_q  <= ST_BIT_LO;
          tmr_q <= TW'(BLO_C - 1);
        end
        ST_BIT_LO: begin
          st_q  <= ST_BIT_HI;
          tmr_q <= frame_q[FRAME_W-1] ? TW'(ONE_C - 1) : TW'(ZERO_C - 1);
        end
        ST_BIT_HI: begin
          frame_q <= frame_q << 1;
          idx_q   <= idx_q + IW'(1);
          if (idx_q == IW'(FRAME_W - 1)) begin
            st_q  <= ST_TAIL_LO;
            tmr_q <= TW'(TAIL_C - 1);
          end else begin
            st_q  <= ST_BIT_LO;
            tmr_q <= TW'(BLO_C - 1);
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign pull_o = (st_q == ST_ACK_LO) || (st_q == ST_BIT_LO) || (st_q == ST_TAIL_LO);
  assign busy_o = (st_q != ST_IDLE);

  assert_phase_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q != ST_IDLE && tmr_q != '0) |=> st_q == $past(st_q));
  assert_bit_limit_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idx_q <= IW'(FRAME_W));
  assert_frame_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_BIT_LO && $past(st_q == ST_BIT_LO)) |-> $stable(frame_q));
  assert_release_end_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> !pull_o && $past(st_q == ST_TAIL_LO));
endmodule

// File: rtl/hygro_line_responder.sv
module hygro_line_responder
  import hygro_pkg::*;
#(
  parameter int CLK_MHZ      = 100,
  parameter int START_MIN_US = 18000,
  parameter int WAIT_US      = 13,
  parameter int ACK_LO_US    = 83,
  parameter int ACK_HI_US    = 87,
  parameter int BIT_LO_US    = 54,
  parameter int ONE_HI_US    = 71,
  parameter int ZERO_HI_US   = 24,
  parameter int TAIL_LO_US   = 54
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [PAYLOAD_W-1:0] payload_i,
  input  logic                 line_i,
  output logic                 pull_o,
  output logic                 busy_o
);
  localparam int START_CYC = START_MIN_US * CLK_MHZ;

  logic line_s, req;

  hr_line_sync u_sync (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .line_i  (line_i),
    .line_s_o(line_s)
  );

  hr_start_detect #(.START_CYC(START_CYC)) u_det (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .line_s_i(line_s),
    .busy_i  (busy_o),
    .req_o   (req)
  );

  hr_frame_sender #(
    .CLK_MHZ   (CLK_MHZ),
    .WAIT_US   (WAIT_US),
    .ACK_LO_US (ACK_LO_US),
    .ACK_HI_US (ACK_HI_US),
    .BIT_LO_US (BIT_LO_US),
    .ONE_HI_US (ONE_HI_US),
    .ZERO_HI_US(ZERO_HI_US),
    .TAIL_LO_US(TAIL_LO_US)
  ) u_tx (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .go_i     (req),
    .payload_i(payload_i),
    .pull_o   (pull_o),
    .busy_o   (busy_o)
  );

  assert_pull_in_frame_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pull_o |-> busy_o);
  assert_no_retrigger_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |=> !busy_o);
endmodule

// File: tb/sim_hygro_line_responder.sv
module sim_hygro_line_responder;
  localparam int START = 200;
  localparam int WAITC = 13, ALO = 83, AHI = 87, BLO = 54, ONE = 71, ZERO = 24, TAIL = 54;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [31:0] payload = '0;
  logic        host_low = 1'b0;
  logic        line, pull, busy;
  int          errors = 0, total = 0;
  bit          done = 1'b0;

  always #5 clk = ~clk;
  assign line = ~(host_low | pull);

  hygro_line_responder #(.CLK_MHZ(1), .START_MIN_US(START)) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .payload_i(payload),
    .line_i(line), .pull_o(pull), .busy_o(busy)
  );

  function automatic logic [7:0] ref_sum(input logic [31:0] p);
    return 8'((p >> 24) + ((p >> 16) & 32'hFF) + ((p >> 8) & 32'hFF) + (p & 32'hFF));
  endfunction

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic host_pulse(input int n);
    @(negedge clk); host_low = 1'b1;
    repeat (n) @(negedge clk);
    host_low = 1'b0;
  endtask

  task automatic run_len(input logic v, output int n);
    n = 0;
    while (pull === v) begin @(negedge clk); n++; end
  endtask

  // called at the negedge where the host releases the line
  task automatic read_frame(input logic [31:0] p, input bit swap);
    int n, lo_bad, hi_bad;
    logic [39:0] got;
    lo_bad = 0; hi_bad = 0; got = '0;
    run_len(1'b0, n);
    check(n >= WAITC && n <= WAITC + 4, "R3 wait", n, WAITC);
    if (swap) payload = ~p;
    run_len(1'b1, n); check(n == ALO, "R3 ack low", n, ALO);
    run_len(1'b0, n); check(n == AHI, "R3 ack high", n, AHI);
    for (int i = 0; i < 40; i++) begin
      run_len(1'b1, n);
      if (n != BLO) lo_bad++;
      run_len(1'b0, n);
      got = got << 1;
      if (n == ONE) got[0] = 1'b1;
      else if (n != ZERO) hi_bad++;
    end
    check(lo_bad == 0, "R4 bit low widths", lo_bad, 0);
    check(hi_bad == 0, "R4 bit high widths", hi_bad, 0);
    run_len(1'b1, n); check(n == TAIL, "R7 tail low", n, TAIL);
    check(busy == 1'b0, "R7 busy drop", busy, 0);
    check(got == {p, ref_sum(p)}, swap ? "R8 frame held" : "R5 frame", got, {p, ref_sum(p)});
    check(got[7:0] == ref_sum(got[39:8]), "R6 checksum", got[7:0], ref_sum(got[39:8]));
  endtask

  task automatic watch_idle(input int n, input string tag);
    int bad;
    bad = 0;
    repeat (n) begin @(negedge clk); if (busy || pull) bad++; end
    check(bad == 0, tag, bad, 0);
  endtask

  initial begin
    logic [31:0] p;
    repeat (3) @(negedge clk);
    check(pull == 1'b0 && busy == 1'b0, "R1 in reset", {pull, busy}, 0);
    rst_ni = 1'b1;
    @(negedge clk);
    check(pull == 1'b0 && busy == 1'b0, "R1 after reset", {pull, busy}, 0);
    watch_idle(20, "R1 idle");

    host_pulse(START - 1);
    watch_idle(300, "R2 short pulse ignored");

    payload = 32'h3300_5500;
    host_pulse(START);
    read_frame(payload, 1'b0);
    watch_idle(30, "R9 no self trigger");

    for (int k = 0; k < 10; k++) begin
      case (k)
        0: p = 32'h0000_0000;
        1: p = 32'hFFFF_FFFF;
        2: p = 32'h8080_8080;
        default: p = 32'h9E37_79B9 * 32'(k);
      endcase
      payload = p;
      host_pulse(START + 7 * k);
      read_frame(p, 1'b0);
      repeat (10) @(negedge clk);
    end

    // R8: payload changes mid-frame
    p = 32'h4120_1A85;
    payload = p;
    host_pulse(START + 3);
    read_frame(p, 1'b1);
    repeat (10) @(negedge clk);

    // R9: host start pulse during a frame
    p = 32'h5A3C_0F81;
    payload = p;
    host_pulse(START);
    fork
      read_frame(p, 1'b0);
      begin repeat (1000) @(negedge clk); host_pulse(START + 50); end
    join
    watch_idle(300, "R9 request while busy ignored");

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, total);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++; total++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("Result: errors=%0d of %0d checks", errors, total);
      $finish;
    end
  end
endmodule